// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the SDRAM command pins from reset until the memory is ready for ordinary traffic. After reset is released it waits out a long settling pause while keeping the device quiet. It then closes every bank with a precharge-all command and issues a fixed burst of eight auto-refresh commands. It also writes the mode register from a parameter word. Every gap between commands is a parameter counted in clock cycles, so the same code serves any clock rate.

The order of the refresh burst relative to the mode register write is chosen at build time. When the last required wait has elapsed, the block raises a completion flag and releases the data mask. After that it only drives idle commands. A downstream controller waits for the flag and then takes over the command bus.

Reset is asynchronous and active low, and its release is synchronised internally through two flops. All pin outputs come straight from flops.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst_n` is low, the outputs are the idle command (`cs_n`=0, `ras_n`=`cas_n`=`we_n`=1), `cke`=1, `dqm` all ones, `addr`=0, `ba`=0 and `init_done`=0. The sequence starts counting two clock edges after `rst_n` rises.
- R2: Counting rising edges after `rst_n` rises, the outputs show only idle commands up to and including edge `PAUSE_CYC`+1. No refresh or mode write ever comes before the precharge-all.
- R3: `cke` stays high at all times. `dqm` is all ones until `init_done` rises and is all zeros from then on.
- R4: The precharge-all appears after edge `PAUSE_CYC`+2. It is encoded as `cs_n`=0, `ras_n`=0, `cas_n`=1, `we_n`=0, with `addr` bit `AP_BIT` (default 10) set, every other address bit clear, and `ba`=0.
- R5: The command after the precharge-all comes exactly `T_RP` edges after it.
- R6: The mode register write is encoded as `cs_n`=`ras_n`=`cas_n`=`we_n`=0, with `addr`=`MODE_WORD` and `ba`=0. `cke` was already high in the cycle before it.
- R7: Exactly `N_REF` (8) auto-refreshes are issued. Each is encoded as `cs_n`=`ras_n`=`cas_n`=0, `we_n`=1, `addr`=0. Two consecutive refreshes are exactly `T_RC` edges apart, and idle commands fill every gap.
- R8: With `REF_FIRST`=1 all refreshes come between the precharge-all and the mode write. With `REF_FIRST`=0 they all come after the mode write.
- R9: The event that follows the mode register write, either a refresh or the rise of `init_done`, happens exactly `T_RSC` edges after it.
- R10: `init_done` rises exactly one wait (`T_RC` after a last refresh, `T_RSC` after a last mode write) after the final command. It then stays high with idle commands on the bus until the next reset.
- R11: Asserting `rst_n` in the middle of the sequence returns every output to the R1 state at once. After release the whole sequence restarts from the pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| dqm | output | DQM_W | Data mask, high while initializing |
| addr | output | ADDR_W | Address bus (all-bank bit, mode word) |
| ba | output | BA_W | Bank address, zero throughout |
| init_done | output | 1 | Sticky completion flag |

## Verification
Nearly any internal fault moves a command edge, and the bench checks every pin on every cycle. A wrong wait counter shows up as a precharge, refresh or mode write one or more cycles early or late, at the first command that uses that wait. A refresh counter that is off by one adds or removes a refresh and shifts `init_done`. A wrong ordering choice puts the mode write on the wrong side of the refresh burst, which the first differing command reveals. A stuck done flag or a mask that is never released is caught in the cycle it should change.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_PRE = 2'd1,
    CMD_REF = 2'd2,
    CMD_MRS = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    ST_PAUSE    = 3'd0,
    ST_PRE_WAIT = 3'd1,
    ST_REF_WAIT = 3'd2,
    ST_MRS_WAIT = 3'd3,
    ST_DONE     = 3'd4
  } state_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_rst_sync.sv
module sdram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  // assert immediately, release after STAGES edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/sdram_wait_timer.sv
module sdram_wait_timer #(
  parameter int           W    = 8,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                   cnt_d = load_val;
    else if (en && cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= INIT;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sdram_ref_counter.sv
module sdram_ref_counter #(
  parameter int N_REF = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  output logic all_done
);

  localparam int CW = $clog2(N_REF + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (inc && cnt_q != CW'(N_REF)) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign all_done = (cnt_q == CW'(N_REF));

endmodule

// File: rtl/sdram_cmd_drive.sv
module sdram_cmd_drive
  import sdram_init_pkg::*;
#(
  parameter int                ADDR_W    = 13,
  parameter int                BA_W      = 2,
  parameter int                DQM_W     = 2,
  parameter int                AP_BIT    = 10,
  parameter logic [ADDR_W-1:0] MODE_WORD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_e              cmd,
  input  logic              done_set,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [DQM_W-1:0]  dqm,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic              init_done
);

  localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << AP_BIT;

  logic [3:0]        pins_d, pins_q;   // {cs_n, ras_n, cas_n, we_n}
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic [DQM_W-1:0]  dqm_d, dqm_q;
  logic              done_d, done_q;

  always_comb begin
    addr_d = '0;
    unique case (cmd)
      CMD_PRE: begin pins_d = 4'b0010; addr_d = ALL_BANKS; end
      CMD_REF: pins_d = 4'b0001;
      CMD_MRS: begin pins_d = 4'b0000; addr_d = MODE_WORD; end
      default: pins_d = 4'b0111;
    endcase
    done_d = done_q | done_set;
    dqm_d  = done_set ? '0 : dqm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q <= 4'b0111;
      addr_q <= '0;
      dqm_q  <= '1;
      done_q <= 1'b0;
    end else begin
      pins_q <= pins_d;
      addr_q <= addr_d;
      dqm_q  <= dqm_d;
      done_q <= done_d;
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = pins_q;
  assign addr      = addr_q;
  assign ba        = '0;
  assign cke       = 1'b1;
  assign dqm       = dqm_q;
  assign init_done = done_q;

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int                ADDR_W    = 13,
  parameter int                BA_W      = 2,
  parameter int                DQM_W     = 2,
  parameter int                PAUSE_CYC = 40000,
  parameter int                T_RP      = 3,
  parameter int                T_RC      = 10,
  parameter int                T_RSC     = 2,
  parameter int                N_REF     = 8,
  parameter int                AP_BIT    = 10,
  parameter logic [ADDR_W-1:0] MODE_WORD = 'h033,
  parameter bit                REF_FIRST = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [DQM_W-1:0]  dqm,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic              init_done
);

  localparam int MAX_WAIT = max_of(max_of(PAUSE_CYC, T_RP), max_of(T_RC, T_RSC));
  localparam int TW       = $clog2(MAX_WAIT + 1);

  localparam logic [TW-1:0] LD_PAUSE = TW'(PAUSE_CYC - 1);
  localparam logic [TW-1:0] LD_RP    = TW'(T_RP - 1);
  localparam logic [TW-1:0] LD_RC    = TW'(T_RC - 1);
  localparam logic [TW-1:0] LD_RSC   = TW'(T_RSC - 1);

  logic          rst_sync_n;
  logic          tmr_zero, tmr_en, tmr_load;
  logic [TW-1:0] tmr_val;
  logic          ref_inc, refs_all, done_set;
  cmd_e          cmd;
  state_e        state_q, state_d;

  sdram_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sdram_wait_timer #(.W(TW), .INIT(LD_PAUSE)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .en       (tmr_en),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  sdram_ref_counter #(.N_REF(N_REF)) u_refc (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .inc      (ref_inc),
    .all_done (refs_all)
  );

  // next-state and command selection
  always_comb begin
    state_d  = state_q;
    cmd      = CMD_NOP;
    tmr_load = 1'b0;
    tmr_val  = '0;
    ref_inc  = 1'b0;
    done_set = 1'b0;
    if (tmr_zero) begin
      unique case (state_q)
        ST_PAUSE: begin
          cmd = CMD_PRE; tmr_load = 1'b1; tmr_val = LD_RP; state_d = ST_PRE_WAIT;
        end
        ST_PRE_WAIT: begin
          if (REF_FIRST) begin
            cmd = CMD_REF; ref_inc = 1'b1; tmr_load = 1'b1; tmr_val = LD_RC;
            state_d = ST_REF_WAIT;
          end else begin
            cmd = CMD_MRS; tmr_load = 1'b1; tmr_val = LD_RSC; state_d = ST_MRS_WAIT;
          end
        end
        ST_REF_WAIT: begin
          if (!refs_all) begin
            cmd = CMD_REF; ref_inc = 1'b1; tmr_load = 1'b1; tmr_val = LD_RC;
          end else if (REF_FIRST) begin
            cmd = CMD_MRS; tmr_load = 1'b1; tmr_val = LD_RSC; state_d = ST_MRS_WAIT;
          end else begin
            done_set = 1'b1; state_d = ST_DONE;
          end
        end
        ST_MRS_WAIT: begin
          if (REF_FIRST) begin
            done_set = 1'b1; state_d = ST_DONE;
          end else begin
            cmd = CMD_REF; ref_inc = 1'b1; tmr_load = 1'b1; tmr_val = LD_RC;
            state_d = ST_REF_WAIT;
          end
        end
        default: state_d = ST_DONE;
      endcase
    end
  end

  assign tmr_en = (state_q != ST_DONE);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= ST_PAUSE;
    else             state_q <= state_d;
  end

  sdram_cmd_drive #(
    .ADDR_W    (ADDR_W),
    .BA_W      (BA_W),
    .DQM_W     (DQM_W),
    .AP_BIT    (AP_BIT),
    .MODE_WORD (MODE_WORD)
  ) u_drv (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cmd       (cmd),
    .done_set  (done_set),
    .cke       (cke),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .dqm       (dqm),
    .addr      (addr),
    .ba        (ba),
    .init_done (init_done)
  );

endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
  parameter int                ADDR_W    = 13,
  parameter int                BA_W      = 2,
  parameter int                DQM_W     = 2,
  parameter int                T_RC      = 10,
  parameter int                T_RSC     = 2,
  parameter int                N_REF     = 8,
  parameter int                AP_BIT    = 10,
  parameter logic [ADDR_W-1:0] MODE_WORD = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [DQM_W-1:0]  dqm,
  input logic [ADDR_W-1:0] addr,
  input logic [BA_W-1:0]   ba,
  input logic              init_done
);

  localparam logic [1:0] L_NONE = 2'd0, L_PRE = 2'd1, L_REF = 2'd2, L_MRS = 2'd3;

  logic is_nop, is_pre, is_ref, is_mrs;
  assign is_nop = !cs_n &&  ras_n &&  cas_n &&  we_n;
  assign is_pre = !cs_n && !ras_n &&  cas_n && !we_n;
  assign is_ref = !cs_n && !ras_n && !cas_n &&  we_n;
  assign is_mrs = !cs_n && !ras_n && !cas_n && !we_n;

  logic [15:0] gap;
  logic [1:0]  last;
  logic        seen_pre;
  logic [7:0]  refs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap <= '0; last <= L_NONE; seen_pre <= 1'b0; refs <= '0;
    end else begin
      if (is_pre || is_ref || is_mrs) begin
        gap  <= 16'd1;
        last <= is_pre ? L_PRE : (is_ref ? L_REF : L_MRS);
      end else if (gap != 16'hFFFF) begin
        gap <= gap + 1'b1;
      end
      if (is_pre) seen_pre <= 1'b1;
      if (is_ref && refs != 8'hFF) refs <= refs + 1'b1;
    end
  end

  p_cke_high_r3: assert property (@(posedge clk) disable iff (!rst_n) cke);
  p_dqm_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> (&dqm));
  p_pre_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ref || is_mrs) |-> seen_pre);
  p_pre_all_banks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> (addr[AP_BIT] && ba == '0));
  p_mrs_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |-> (addr == MODE_WORD && ba == '0 && $past(cke)));
  p_ref_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ref && last == L_REF) |-> (gap >= 16'(T_RC)));
  p_ref_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    refs <= 8'(N_REF));
  p_rsc_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((is_ref || $rose(init_done)) && last == L_MRS) |-> (gap >= 16'(T_RSC)));
  p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (is_nop && dqm == '0));

endmodule

bind sdram_init_seq sdram_init_chk #(
  .ADDR_W    (ADDR_W),
  .BA_W      (BA_W),
  .DQM_W     (DQM_W),
  .T_RC      (T_RC),
  .T_RSC     (T_RSC),
  .N_REF     (N_REF),
  .AP_BIT    (AP_BIT),
  .MODE_WORD (MODE_WORD)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cke       (cke),
  .cs_n      (cs_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .dqm       (dqm),
  .addr      (addr),
  .ba        (ba),
  .init_done (init_done)
);

// File: tb/tb_sdram_init_seq.sv
`timescale 1ns/1ps
module tb_sdram_init_seq;

  localparam int ADDR_W = 13, BA_W = 2, DQM_W = 2, AP = 10;
  localparam logic [ADDR_W-1:0] MODE = 13'h0033;
  // variant A: refreshes before the mode write
  localparam int A_PAUSE = 50, A_RP = 3, A_RC = 5, A_RSC = 2;
  // variant B: refreshes after the mode write
  localparam int B_PAUSE = 40, B_RP = 2, B_RC = 4, B_RSC = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic a_cke, a_cs, a_ras, a_cas, a_we, a_done;
  logic [DQM_W-1:0] a_dqm; logic [ADDR_W-1:0] a_addr; logic [BA_W-1:0] a_ba;
  logic b_cke, b_cs, b_ras, b_cas, b_we, b_done;
  logic [DQM_W-1:0] b_dqm; logic [ADDR_W-1:0] b_addr; logic [BA_W-1:0] b_ba;

  sdram_init_seq #(.ADDR_W(ADDR_W), .BA_W(BA_W), .DQM_W(DQM_W), .PAUSE_CYC(A_PAUSE),
    .T_RP(A_RP), .T_RC(A_RC), .T_RSC(A_RSC), .N_REF(8), .AP_BIT(AP), .MODE_WORD(MODE),
    .REF_FIRST(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .cke(a_cke), .cs_n(a_cs), .ras_n(a_ras), .cas_n(a_cas),
    .we_n(a_we), .dqm(a_dqm), .addr(a_addr), .ba(a_ba), .init_done(a_done));

  sdram_init_seq #(.ADDR_W(ADDR_W), .BA_W(BA_W), .DQM_W(DQM_W), .PAUSE_CYC(B_PAUSE),
    .T_RP(B_RP), .T_RC(B_RC), .T_RSC(B_RSC), .N_REF(8), .AP_BIT(AP), .MODE_WORD(MODE),
    .REF_FIRST(1'b0)) dut_alt (
    .clk(clk), .rst_n(rst_n), .cke(b_cke), .cs_n(b_cs), .ras_n(b_ras), .cas_n(b_cas),
    .we_n(b_we), .dqm(b_dqm), .addr(b_addr), .ba(b_ba), .init_done(b_done));

  int n_chk = 0, n_fail = 0;
  int n_edge = 0;
  int run_id = 0;
  int a_refs = 0, a_refs_pre = 0, b_refs = 0, b_refs_pre = 0;
  bit a_mrs_seen = 0, b_mrs_seen = 0;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s at edge %0d: actual=%0h expected=%0h", tag, what, n_edge, act, exp);
    end
  endtask

  // Behavioural schedule: codes 0 idle, 1 precharge-all, 2 refresh, 3 mode write
  task automatic model(input bit rf, input int pause, input int trp, input int trc,
                       input int trsc, input int n, output int cmd, output bit done,
                       output string tag);
    int seq[10];
    int gp[10];
    int t;
    seq[0] = 1; gp[0] = trp;
    for (int k = 1; k < 10; k++) begin seq[k] = 2; gp[k] = trc; end
    if (rf) begin seq[9] = 3; gp[9] = trsc; end
    else    begin seq[1] = 3; gp[1] = trsc; end
    cmd = 0; done = 1'b0; t = pause + 2;
    for (int i = 0; i < 10; i++) begin
      if (n < t) begin
        tag = (i == 0) ? "R2" : ((seq[i-1] == 3) ? "R9" : "R7");
        return;
      end
      if (n == t) begin
        cmd = seq[i];
        if (i == 1)                    tag = "R5";
        else if (i > 0 && seq[i-1] == 3) tag = "R9";
        else if (seq[i] == 1)          tag = "R4";
        else if (seq[i] == 3)          tag = "R6";
        else                           tag = "R7";
        return;
      end
      t += gp[i];
    end
    if (n < t) tag = (seq[9] == 3) ? "R9" : "R7";
    else begin
      done = 1'b1;
      tag = (n == t && seq[9] == 3) ? "R9" : "R10";
    end
  endtask

  task automatic check_one(input string nm, input bit rf, input int pause, input int trp,
                           input int trc, input int trsc, input logic cke, input logic cs,
                           input logic ras, input logic cas, input logic we,
                           input logic [DQM_W-1:0] dqm, input logic [ADDR_W-1:0] addr,
                           input logic [BA_W-1:0] ba, input logic done);
    int cmd; bit edone; string tag;
    logic [3:0] epins; logic [ADDR_W-1:0] eaddr;
    if (!rst_n) begin
      cmd = 0; edone = 1'b0; tag = "R1";
    end else begin
      model(rf, pause, trp, trc, trsc, n_edge, cmd, edone, tag);
      if (run_id == 2) tag = "R11";
    end
    case (cmd)
      1: begin epins = 4'b0010; eaddr = ADDR_W'(1) << AP; end
      2: begin epins = 4'b0001; eaddr = '0; end
      3: begin epins = 4'b0000; eaddr = MODE; end
      default: begin epins = 4'b0111; eaddr = '0; end
    endcase
    check(tag, {nm, " cmd pins"}, 32'({cs, ras, cas, we}), 32'(epins));
    check(tag, {nm, " addr"}, 32'(addr), 32'(eaddr));
    check(tag, {nm, " ba"}, 32'(ba), 32'd0);
    check(tag, {nm, " init_done"}, 32'(done), 32'(edone));
    check("R3", {nm, " cke"}, 32'(cke), 32'd1);
    check("R3", {nm, " dqm"}, 32'(dqm), edone ? 32'd0 : 32'((1 << DQM_W) - 1));
  endtask

  always @(posedge clk) begin
    if (!rst_n) n_edge <= 0;
    else        n_edge <= n_edge + 1;
  end

  always @(negedge clk) begin
    if (run_id != 0) begin
      check_one("A", 1'b1, A_PAUSE, A_RP, A_RC, A_RSC, a_cke, a_cs, a_ras, a_cas, a_we,
                a_dqm, a_addr, a_ba, a_done);
      check_one("B", 1'b0, B_PAUSE, B_RP, B_RC, B_RSC, b_cke, b_cs, b_ras, b_cas, b_we,
                b_dqm, b_addr, b_ba, b_done);
      if (rst_n) begin
        if ({a_cs, a_ras, a_cas, a_we} == 4'b0001) begin
          a_refs++; if (!a_mrs_seen) a_refs_pre++;
        end
        if ({a_cs, a_ras, a_cas, a_we} == 4'b0000) a_mrs_seen = 1'b1;
        if ({b_cs, b_ras, b_cas, b_we} == 4'b0001) begin
          b_refs++; if (!b_mrs_seen) b_refs_pre++;
        end
        if ({b_cs, b_ras, b_cas, b_we} == 4'b0000) b_mrs_seen = 1'b1;
      end
    end
  end

  task automatic clear_counts();
    a_refs = 0; a_refs_pre = 0; b_refs = 0; b_refs_pre = 0;
    a_mrs_seen = 1'b0; b_mrs_seen = 1'b0;
  endtask

  task automatic check_order(input string t7, input string t8);
    check(t7, "A refresh total", 32'(a_refs), 32'd8);
    check(t7, "B refresh total", 32'(b_refs), 32'd8);
    check(t8, "A refreshes before mode write", 32'(a_refs_pre), 32'd8);
    check(t8, "B refreshes before mode write", 32'(b_refs_pre), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    run_id = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (130) @(posedge clk);
    check_order("R7", "R8");

    // mid-sequence reset, then a full restart
    #1 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    clear_counts();
    run_id = 2;
    #1 rst_n = 1'b1;
    repeat (70) @(posedge clk);
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    clear_counts();
    #1 rst_n = 1'b1;
    repeat (130) @(posedge clk);
    check_order("R11", "R11");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule